// File: doc/BRIEF.md
# Double-Buffered Byte-and-Nibble DAC Load Controller

This block is the digital front end of a 12-bit digital-to-analog converter that is fed from an 8-bit bus. A 12-bit staging register is written in two separate accesses. The low byte is written under its own select, and the top nibble is written under a second select from the low four bus lines. Each access is a level-sensitive write: while the write strobe and one select are both low, that part of the staging register follows the bus. The part freezes as soon as either strobe goes high.

A separate load strobe copies the staging register into the output code register, so a new 12-bit value reaches the converter in one step and never half-written. Two override inputs force the output code to full scale or to zero without disturbing the staged value. A mode input gives a signed view of the code, either as plain binary or as offset binary centred on 2048. All control inputs are asynchronous active-low levels. They are sampled on the system clock through a synchronizer, and the block pulses a flag for one cycle whenever the output code changes.

Top module: `dac_load_ctrl`

## Requirements
- R1: While rst_ni is low and just after it is released, dac_code_o is 0, value_o is 0 and chg_o is 0. The staging register also resets to 0, so a load strobe right after reset leaves dac_code_o at 0.
- R2: With wr_ni and cs_lo_ni low and cs_hi_ni high, staging bits 7..0 follow data_i[7..0]. When wr_ni rises first, those bits keep the last value seen before the rise, even if data_i changes afterwards.
- R3: If cs_lo_ni rises before wr_ni during a low-byte write, the low byte is frozen at that point. Bus changes made while wr_ni is still low have no effect.
- R4: With wr_ni and cs_hi_ni low and cs_lo_ni high, staging bits 11..8 follow data_i[3..0], and data_i[7..4] is ignored. The high nibble freezes on the first rise of wr_ni or cs_hi_ni, and the low byte is left unchanged.
- R5: When wr_ni, cs_lo_ni and cs_hi_ni are all low together, neither part of the staging register is written.
- R6: While wr_ni is high, or while both selects are high, the staging register holds its value.
- R7: While ldac_ni is low (and set_ni and clr_ni are high), dac_code_o follows the staging register. While ldac_ni is high, dac_code_o holds.
- R8: While set_ni is low, dac_code_o is 4095, whatever the levels of clr_ni and ldac_ni.
- R9: While clr_ni is low and set_ni is high, dac_code_o is 0.
- R10: The overrides leave the staging register untouched. After they are released, a load strobe puts the value staged before the override onto dac_code_o.
- R11: value_o is a 13-bit signed number. It equals dac_code_o when bipolar_i is 0, and dac_code_o - 2048 when bipolar_i is 1.
- R12: chg_o is high for exactly the one cycle in which dac_code_o first shows a new value. Reloading an equal value gives no pulse.
- R13: With ldac_ni held low and a low-byte write open, a change on data_i that is set up before a rising clock edge shows on dac_code_o after the fourth rising edge, counting that one, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus; bits 3..0 also carry the high nibble |
| wr_ni | input | 1 | Write strobe, active low |
| cs_lo_ni | input | 1 | Low-byte select, active low |
| cs_hi_ni | input | 1 | High-nibble select, active low |
| ldac_ni | input | 1 | Staging-to-output transfer, active low, level sensitive |
| set_ni | input | 1 | Force output code to all ones, active low, highest priority |
| clr_ni | input | 1 | Force output code to zero, active low |
| bipolar_i | input | 1 | 1 selects offset-binary signed view on value_o |
| dac_code_o | output | 12 | Output code register |
| value_o | output | 13 | Signed view of the output code |
| chg_o | output | 1 | One-cycle pulse when dac_code_o changes |

## Verification
The bench builds the block with its default 8-bit low part, 4-bit high part and two-stage synchronizer, so the full 12-bit code has 4096 values. It writes every high nibble against 32 spread low bytes, with junk on the unused bus bits and the mode toggled. This covers both nibble lanes, both signed views, and the value boundaries 0, 2048 and 4095. Separate directed sequences cover the freeze ordering (write strobe first versus select first), the illegal double select, override priority and persistence, the exact four-edge latency, and the absence of a change pulse on an equal reload.

// File: rtl/dac_load_pkg.sv
`timescale 1ns/1ps
package dac_load_pkg;
  typedef struct packed {
    logic wr_n;
    logic cs_lo_n;
    logic cs_hi_n;
    logic ldac_n;
    logic set_n;
    logic clr_n;
  } strobes_t;

  localparam int unsigned STROBE_W = $bits(strobes_t);
  localparam strobes_t STROBES_IDLE = '{default: 1'b1};
endpackage

// File: rtl/dac_strobe_sync.sv
`timescale 1ns/1ps
module dac_strobe_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_input_reg.sv
`timescale 1ns/1ps
module dac_input_reg #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 4,
  localparam int unsigned CODE_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_n_i,
  input  logic              cs_lo_n_i,
  input  logic              cs_hi_n_i,
  input  logic [LO_W-1:0]   data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic lo_en, hi_en;

  // each lane is transparent only while its own select is the single one active
  assign lo_en = !wr_n_i && !cs_lo_n_i &&  cs_hi_n_i;
  assign hi_en = !wr_n_i &&  cs_lo_n_i && !cs_hi_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (lo_en) lo_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (hi_en) hi_q <= data_i[HI_W-1:0];
  end

  assign code_o = {hi_q, lo_q};

  AST_LO_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_i && !cs_lo_n_i && cs_hi_n_i) |=> (code_o[LO_W-1:0] == $past(data_i))); // R2
  AST_HI_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_i && cs_lo_n_i && !cs_hi_n_i) |=>
      (code_o[CODE_W-1:LO_W] == $past(data_i[HI_W-1:0]) && $stable(code_o[LO_W-1:0]))); // R4
  AST_DUAL_SEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_i && !cs_lo_n_i && !cs_hi_n_i) |=> $stable(code_o)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_n_i || (cs_lo_n_i && cs_hi_n_i)) |=> $stable(code_o)); // R6
endmodule

// File: rtl/dac_output_reg.sv
`timescale 1ns/1ps
module dac_output_reg #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldac_n_i,
  input  logic              set_n_i,
  input  logic              clr_n_i,
  input  logic [CODE_W-1:0] stage_i,
  output logic [CODE_W-1:0] code_o,
  output logic              chg_o
);
  logic [CODE_W-1:0] code_d, code_q;
  logic              chg_q;

  always_comb begin
    code_d = code_q;
    if (!set_n_i)       code_d = '1;
    else if (!clr_n_i)  code_d = '0;
    else if (!ldac_n_i) code_d = stage_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      chg_q  <= (code_d != code_q);
    end
  end

  assign code_o = code_q;
  assign chg_o  = chg_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_n_i |=> (code_o == {CODE_W{1'b1}})); // R8
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_n_i && !clr_n_i) |=> (code_o == '0)); // R9
  AST_LOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_n_i && clr_n_i && !ldac_n_i) |=> (code_o == $past(stage_i))); // R7
  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_n_i && clr_n_i && ldac_n_i) |=> ($stable(code_o) && !chg_o)); // R12
endmodule

// File: rtl/dac_load_ctrl.sv
`timescale 1ns/1ps
module dac_load_ctrl #(
  parameter int unsigned LO_W        = 8,
  parameter int unsigned HI_W        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CODE_W     = LO_W + HI_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LO_W-1:0]          data_i,
  input  logic                     wr_ni,
  input  logic                     cs_lo_ni,
  input  logic                     cs_hi_ni,
  input  logic                     ldac_ni,
  input  logic                     set_ni,
  input  logic                     clr_ni,
  input  logic                     bipolar_i,
  output logic [CODE_W-1:0]        dac_code_o,
  output logic signed [CODE_W:0]   value_o,
  output logic                     chg_o
);
  import dac_load_pkg::*;

  localparam int unsigned SYNC_W = STROBE_W + LO_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {STROBES_IDLE, {LO_W{1'b0}}};
  localparam logic signed [CODE_W:0] MID = $signed({2'b01, {(CODE_W-1){1'b0}}});

  strobes_t          strb_raw, strb_s;
  logic [LO_W-1:0]   data_s;
  logic [CODE_W-1:0] stage_code;

  assign strb_raw = '{wr_n: wr_ni, cs_lo_n: cs_lo_ni, cs_hi_n: cs_hi_ni,
                      ldac_n: ldac_ni, set_n: set_ni, clr_n: clr_ni};

  // data rides the same synchronizer so it stays aligned with the strobes
  dac_strobe_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({strb_raw, data_i}),
    .q_o   ({strb_s, data_s})
  );

  dac_input_reg #(
    .LO_W(LO_W),
    .HI_W(HI_W)
  ) i_input_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_n_i   (strb_s.wr_n),
    .cs_lo_n_i(strb_s.cs_lo_n),
    .cs_hi_n_i(strb_s.cs_hi_n),
    .data_i   (data_s),
    .code_o   (stage_code)
  );

  dac_output_reg #(
    .CODE_W(CODE_W)
  ) i_output_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ldac_n_i(strb_s.ldac_n),
    .set_n_i (strb_s.set_n),
    .clr_n_i (strb_s.clr_n),
    .stage_i (stage_code),
    .code_o  (dac_code_o),
    .chg_o   (chg_o)
  );

  always_comb begin
    value_o = $signed({1'b0, dac_code_o});
    if (bipolar_i) value_o = $signed({1'b0, dac_code_o}) - MID;
  end

  initial begin
    AST_PARAM_NIBBLE: assert (HI_W >= 1 && HI_W <= LO_W); // R4
  end
endmodule

// File: tb/test_dac_load_ctrl.sv
`timescale 1ns/1ps
module test_dac_load_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data = 8'h00;
  logic wr_n = 1'b1, cs_lo_n = 1'b1, cs_hi_n = 1'b1;
  logic ldac_n = 1'b1, set_n = 1'b1, clr_n = 1'b1, bip = 1'b0;
  logic [11:0] code;
  logic signed [12:0] val;
  logic chg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_load_ctrl i_dac_load_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .wr_ni(wr_n),
    .cs_lo_ni(cs_lo_n), .cs_hi_ni(cs_hi_n), .ldac_ni(ldac_n),
    .set_ni(set_n), .clr_ni(clr_n), .bipolar_i(bip),
    .dac_code_o(code), .value_o(val), .chg_o(chg)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_code(input string req, input int exp);
    chk(int'(code) == exp, req, int'(code), exp);
  endtask

  task automatic write_lo(input logic [7:0] b, input bit cs_first);
    data = b; wr_n = 1'b0; cs_lo_n = 1'b0;
    step(1);
    if (cs_first) cs_lo_n = 1'b1; else wr_n = 1'b1;
    step(1);
    wr_n = 1'b1; cs_lo_n = 1'b1;
    step(1);
    data = ~b;
    step(3);
  endtask

  task automatic write_hi(input logic [7:0] b, input bit cs_first);
    data = b; wr_n = 1'b0; cs_hi_n = 1'b0;
    step(1);
    if (cs_first) cs_hi_n = 1'b1; else wr_n = 1'b1;
    step(1);
    wr_n = 1'b1; cs_hi_n = 1'b1;
    step(1);
    data = ~b;
    step(3);
  endtask

  task automatic load_pulse();
    ldac_n = 1'b0;
    step(1);
    ldac_n = 1'b1;
    step(5);
  endtask

  initial begin
    step(3);
    chk(code == 12'd0, "R1", int'(code), 0);
    chk(val == 13'sd0, "R1", int'(val), 0);
    chk(chg == 1'b0, "R1", int'(chg), 0);
    rst_n = 1'b1;
    step(2);
    load_pulse();
    chk_code("R1", 0);

    // sweep: every high nibble against 32 low bytes, junk on data[7:4]
    for (int h = 0; h < 16; h++) begin
      for (int k = 0; k < 32; k++) begin
        automatic logic [7:0] lo = 8'((k * 37 + h * 11) & 255);
        automatic int exp = h * 256 + int'(lo);
        bip = k[0];
        write_lo(lo, k[1]);
        write_hi({4'(k), 4'(h)}, k[2]);
        load_pulse();
        chk_code(k[1] ? "R3" : "R2", exp);
        chk_code("R4", exp);
        chk(int'(val) == (bip ? exp - 2048 : exp), "R11", int'(val), bip ? exp - 2048 : exp);
      end
    end

    // value boundaries: 0x800 and 0xFFF
    write_lo(8'h00, 1'b0); write_hi(8'hF8, 1'b0); load_pulse();
    bip = 1'b1; #1;
    chk(val == 13'sd0, "R11", int'(val), 0);
    write_lo(8'hFF, 1'b0); write_hi(8'h0F, 1'b0); load_pulse();
    #1;
    chk(int'(val) == 2047, "R11", int'(val), 2047);
    bip = 1'b0; #1;
    chk(int'(val) == 4095, "R11", int'(val), 4095);

    // R3: select rises first, later bus change under low wr is ignored
    write_lo(8'h00, 1'b0); write_hi(8'h03, 1'b0); load_pulse();
    data = 8'hA5; wr_n = 1'b0; cs_lo_n = 1'b0;
    step(3);
    cs_lo_n = 1'b1;
    step(1);
    data = 8'h5A;
    step(4);
    wr_n = 1'b1;
    step(3);
    load_pulse();
    chk_code("R3", 12'h3A5);

    // R5: both selects low writes nothing
    data = 8'h77; wr_n = 1'b0; cs_lo_n = 1'b0; cs_hi_n = 1'b0;
    step(5);
    wr_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1;
    step(3);
    load_pulse();
    chk_code("R5", 12'h3A5);

    // R6: selects low but wr high, bus toggles
    cs_lo_n = 1'b0; cs_hi_n = 1'b1; data = 8'h11;
    step(4);
    cs_lo_n = 1'b1; cs_hi_n = 1'b0; data = 8'h0C;
    step(4);
    cs_hi_n = 1'b1;
    step(3);
    load_pulse();
    chk_code("R6", 12'h3A5);

    // R7: new staged value not visible while ldac high
    write_lo(8'h42, 1'b0);
    step(4);
    chk_code("R7", 12'h3A5);
    load_pulse();
    chk_code("R7", 12'h342);

    // R8: set beats clr and ldac
    set_n = 1'b0; clr_n = 1'b0; ldac_n = 1'b0;
    step(4);
    chk_code("R8", 4095);
    ldac_n = 1'b1;
    // R9: clr alone
    set_n = 1'b1;
    step(4);
    chk_code("R9", 0);
    clr_n = 1'b1;
    step(4);
    chk_code("R10", 0);
    load_pulse();
    chk_code("R10", 12'h342);

    // R12: equal reload gives no pulse
    ldac_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(chg == 1'b0, "R12", int'(chg), 0);
    end
    // R13 latency with ldac held low and low-byte write open
    wr_n = 1'b0; cs_lo_n = 1'b0; data = 8'h42;
    step(6);
    chk_code("R13", 12'h342);
    data = 8'hE7;
    step(3);
    chk_code("R13", 12'h342);
    chk(chg == 1'b0, "R12", int'(chg), 0);
    step(1);
    chk_code("R13", 12'h3E7);
    chk(chg == 1'b1, "R12", int'(chg), 1);
    step(1);
    chk(chg == 1'b0, "R12", int'(chg), 0);
    wr_n = 1'b1; cs_lo_n = 1'b1; ldac_n = 1'b1;
    step(4);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule